// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a synchronous host and an external asynchronous static RAM of 128K bytes. The host issues single-beat reads and writes over a valid/ready port. The controller turns each request into a timed sequence of strobes on the memory pins: a 17-bit address, an active-low chip select, an active-high chip select, an active-low output enable and an active-low write enable. It also drives the output-enable control and outgoing data of the shared bidirectional data bus.

Phase lengths are parameters counted in clock cycles. They are chosen so that the memory's minimum read access time, write pulse width and data setup time are met at the clock in use. Write cycles are timed by the write enable. The output enable stays high for the whole write, and the controller drives the bus only while write enable is low. A deselected turnaround gap follows every access, so the memory and the controller never drive the bus at the same time.

Top module: `sram_ctl`

## Requirements
- R1: While reset is high and in the first cycle after it: `mem_cs1_n`=1, `mem_cs2`=0, `mem_oe_n`=1, `mem_we_n`=1, `mem_dq_oe`=0, `req_ready`=1 and `rsp_valid`=0.
- R2: `req_ready` is high only when the controller is idle. A request is taken only on a clock edge where `req_valid` and `req_ready` are both high. While the controller is busy, any activity on the request port has no effect.
- R3: A read (`req_write`=0) holds the memory in read mode for exactly RD_CYC cycles, starting the cycle after acceptance. Read mode means `mem_cs1_n`=0, `mem_cs2`=1, `mem_oe_n`=0, `mem_we_n`=1 and `mem_dq_oe`=0, with `mem_addr` equal to the requested address.
- R4: The byte on `mem_dq_in` during the last read-mode cycle is captured. `rsp_valid` is high for exactly one cycle, the cycle after the last read-mode cycle, and `rsp_rdata` carries that byte. A write never raises `rsp_valid`.
- R5: A write (`req_write`=1) starts with one setup cycle in which the chip is selected and `mem_we_n`, `mem_oe_n` are high and `mem_dq_oe` is 0. Then follow WR_CYC cycles with `mem_we_n`=0, `mem_dq_oe`=1, and `mem_dq_out` equal to the request data.
- R6: `mem_oe_n` is high in every cycle of a write. `mem_dq_oe` is high only in cycles where `mem_we_n` is low.
- R7: Every access ends with TA_CYC turnaround cycles in which both chip selects are inactive, all strobes are high and the driver is off. Only after these cycles does `req_ready` rise.
- R8: `mem_addr` stays constant in every cycle in which the chip remains selected.
- R9: A read keeps `req_ready` low for RD_CYC+TA_CYC cycles. A write keeps it low for 1+WR_CYC+TA_CYC cycles.
- R10: The two chip selects always change in the same cycle (`mem_cs1_n` equals the inverse of `mem_cs2`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle, request may be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | One-cycle read response strobe |
| rsp_rdata | output | DW | Captured read byte |
| mem_addr | output | AW | Memory address lines |
| mem_cs1_n | output | 1 | Active-low chip select |
| mem_cs2 | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dq_oe | output | 1 | Enable for the controller's data bus driver |
| mem_dq_out | output | DW | Data driven onto the bus |
| mem_dq_in | input | DW | Data sampled from the bus |

## Verification
The bench builds the controller with AW=5, RD_CYC=3, WR_CYC=2 and TA_CYC=2. The 5-bit address allows every word of the memory stand-in to be written and read back. The short phases make it cheap to compare the pin pattern cycle by cycle on each access. The stand-in returns valid data only from the third read-mode cycle onward, so capturing too early shows up as a wrong byte. During one read-back pass, a competing write request is held on the port while the controller is busy, and a second pass confirms that memory was not changed.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WSETUP,
        ST_WPULSE,
        ST_TURN
    } state_t;

    typedef struct packed {
        logic cs1_n;
        logic cs2;
        logic oe_n;
        logic we_n;
        logic drv;
    } pins_t;

    localparam pins_t PINS_OFF   = '{cs1_n: 1'b1, cs2: 1'b0, oe_n: 1'b1, we_n: 1'b1, drv: 1'b0};
    localparam pins_t PINS_READ  = '{cs1_n: 1'b0, cs2: 1'b1, oe_n: 1'b0, we_n: 1'b1, drv: 1'b0};
    localparam pins_t PINS_WSET  = '{cs1_n: 1'b0, cs2: 1'b1, oe_n: 1'b1, we_n: 1'b1, drv: 1'b0};
    localparam pins_t PINS_WPULS = '{cs1_n: 1'b0, cs2: 1'b1, oe_n: 1'b1, we_n: 1'b0, drv: 1'b1};

    function automatic pins_t pins_of(state_t s);
        case (s)
            ST_READ:   return PINS_READ;
            ST_WSETUP: return PINS_WSET;
            ST_WPULSE: return PINS_WPULS;
            default:   return PINS_OFF;
        endcase
    endfunction

    function automatic int max3(int a, int b, int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/sram_ctl_fsm.sv
module sram_ctl_fsm
    import sram_ctl_pkg::*;
#(
    parameter int AW     = 17,
    parameter int DW     = 8,
    parameter int RD_CYC = 2,
    parameter int WR_CYC = 2,
    parameter int TA_CYC = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          req_ready,
    output state_t        state,
    output logic          rd_last,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] wdata_q
);
    localparam int MAXC = max3(RD_CYC, WR_CYC, TA_CYC);
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] RD_LOAD = CW'(RD_CYC - 1);
    localparam logic [CW-1:0] WR_LOAD = CW'(WR_CYC - 1);
    localparam logic [CW-1:0] TA_LOAD = CW'(TA_CYC - 1);

    logic [CW-1:0] cnt_q;
    logic          cnt_zero;

    assign cnt_zero  = (cnt_q == '0);
    assign req_ready = (state == ST_IDLE);
    assign rd_last   = (state == ST_READ) && cnt_zero;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cnt_q   <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        addr_q  <= req_addr;
                        wdata_q <= req_wdata;
                        if (req_write) begin
                            state <= ST_WSETUP;
                            cnt_q <= '0;
                        end else begin
                            state <= ST_READ;
                            cnt_q <= RD_LOAD;
                        end
                    end
                end
                ST_READ: begin
                    if (cnt_zero) begin
                        state <= ST_TURN;
                        cnt_q <= TA_LOAD;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                ST_WSETUP: begin
                    state <= ST_WPULSE;
                    cnt_q <= WR_LOAD;
                end
                ST_WPULSE: begin
                    if (cnt_zero) begin
                        state <= ST_TURN;
                        cnt_q <= TA_LOAD;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: begin
                    if (cnt_zero) begin
                        state <= ST_IDLE;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/sram_ctl_pins.sv
module sram_ctl_pins
    import sram_ctl_pkg::*;
(
    input  state_t state,
    output logic   cs1_n,
    output logic   cs2,
    output logic   oe_n,
    output logic   we_n,
    output logic   drv
);
    pins_t p;

    always_comb begin
        p     = pins_of(state);
        cs1_n = p.cs1_n;
        cs2   = p.cs2;
        oe_n  = p.oe_n;
        we_n  = p.we_n;
        drv   = p.drv;
    end
endmodule

// File: rtl/sram_ctl_rdcap.sv
module sram_ctl_rdcap #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          capture,
    input  logic [DW-1:0] din,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= capture;
            if (capture) begin
                rsp_rdata <= din;
            end
        end
    end
endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int AW     = 17,
    parameter int DW     = 8,
    parameter int RD_CYC = 2,
    parameter int WR_CYC = 2,
    parameter int TA_CYC = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    output logic [AW-1:0] mem_addr,
    output logic          mem_cs1_n,
    output logic          mem_cs2,
    output logic          mem_oe_n,
    output logic          mem_we_n,
    output logic          mem_dq_oe,
    output logic [DW-1:0] mem_dq_out,
    input  logic [DW-1:0] mem_dq_in
);
    state_t        state;
    logic          rd_last;
    logic [DW-1:0] wdata_q;

    sram_ctl_fsm #(
        .AW(AW), .DW(DW), .RD_CYC(RD_CYC), .WR_CYC(WR_CYC), .TA_CYC(TA_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_ready (req_ready),
        .state     (state),
        .rd_last   (rd_last),
        .addr_q    (mem_addr),
        .wdata_q   (wdata_q)
    );

    sram_ctl_pins u_pins (
        .state (state),
        .cs1_n (mem_cs1_n),
        .cs2   (mem_cs2),
        .oe_n  (mem_oe_n),
        .we_n  (mem_we_n),
        .drv   (mem_dq_oe)
    );

    sram_ctl_rdcap #(.DW(DW)) u_cap (
        .clk       (clk),
        .rst       (rst),
        .capture   (rd_last),
        .din       (mem_dq_in),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    assign mem_dq_out = wdata_q;
endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk #(
    parameter int AW = 17
) (
    input logic          clk,
    input logic          rst,
    input logic          req_valid,
    input logic          req_ready,
    input logic          rsp_valid,
    input logic [AW-1:0] mem_addr,
    input logic          mem_cs1_n,
    input logic          mem_oe_n,
    input logic          mem_we_n,
    input logic          mem_dq_oe
);
    assert_idle_deselected_R2: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (mem_cs1_n && !mem_dq_oe));

    assert_take_drops_ready_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    assert_rsp_single_R4: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    assert_setup_before_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_we_n) |-> $past(!mem_cs1_n));

    assert_oe_off_in_write_R6: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> mem_oe_n);

    assert_drive_in_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> !mem_we_n);

    assert_turn_before_ready_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(req_ready) |-> $past(mem_cs1_n));

    assert_addr_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!mem_cs1_n && $past(!mem_cs1_n)) |-> $stable(mem_addr));
endmodule

bind sram_ctl sram_ctl_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .mem_addr  (mem_addr),
    .mem_cs1_n (mem_cs1_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/sim_sram_ctl.sv
`timescale 1ns/1ps
module sim_sram_ctl;
    localparam int AW    = 5;
    localparam int DW    = 8;
    localparam int RD    = 3;
    localparam int WR    = 2;
    localparam int TA    = 2;
    localparam int WORDS = 1 << AW;

    // pin vector order: {cs1_n, cs2, oe_n, we_n, dq_oe}
    localparam logic [4:0] P_OFF  = 5'b10110;
    localparam logic [4:0] P_RD   = 5'b01010;
    localparam logic [4:0] P_WSET = 5'b01110;
    localparam logic [4:0] P_WPLS = 5'b01101;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic [AW-1:0] mem_addr;
    logic          mem_cs1_n, mem_cs2, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [DW-1:0] mem_dq_out;
    logic [DW-1:0] mem_dq_in;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    sram_ctl #(.AW(AW), .DW(DW), .RD_CYC(RD), .WR_CYC(WR), .TA_CYC(TA)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
        .mem_cs1_n(mem_cs1_n), .mem_cs2(mem_cs2), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_dq_oe(mem_dq_oe), .mem_dq_out(mem_dq_out),
        .mem_dq_in(mem_dq_in)
    );

    // memory stand-in: data valid only from the RD-th read-mode cycle
    logic [DW-1:0] mem [WORDS];
    logic          rsel, wsel;
    int            rd_age = 0;
    assign rsel = !mem_cs1_n && mem_cs2 && !mem_oe_n && mem_we_n;
    assign wsel = !mem_cs1_n && mem_cs2 && !mem_we_n && mem_dq_oe;
    assign mem_dq_in = (rsel && rd_age >= RD - 1) ? mem[mem_addr] : 8'hEE;

    initial begin
        for (int i = 0; i < WORDS; i++) mem[i] = '0;
    end

    always @(posedge clk) begin
        rd_age <= rsel ? rd_age + 1 : 0;
        if (wsel) mem[mem_addr] <= mem_dq_out;
    end

    function automatic logic [DW-1:0] pat(int a);
        return DW'((a * 37 + 5) & 8'hFF);
    endfunction

    function automatic logic [4:0] pins();
        return {mem_cs1_n, mem_cs2, mem_oe_n, mem_we_n, mem_dq_oe};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic do_write(input int a, input logic [DW-1:0] d);
        @(negedge clk);
        chk(req_ready, "R2 ready before write", 32'(req_ready), 1);
        req_valid = 1'b1; req_write = 1'b1;
        req_addr = AW'(a); req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        chk(pins() == P_WSET && mem_addr == AW'(a), "R5 setup cycle",
            {pins(), 27'(mem_addr)}, {P_WSET, 27'(a)});
        chk(!req_ready, "R9 busy in write setup", 32'(req_ready), 0);
        for (int c = 0; c < WR; c++) begin
            @(negedge clk);
            chk(pins() == P_WPLS && mem_dq_out == d && !rsp_valid, "R5 R6 write pulse",
                {pins(), rsp_valid, 18'd0, mem_dq_out}, {P_WPLS, 1'b0, 18'd0, d});
        end
        for (int c = 0; c < TA; c++) begin
            @(negedge clk);
            chk(pins() == P_OFF && !req_ready && !rsp_valid, "R7 write turnaround",
                {pins(), req_ready, rsp_valid}, {P_OFF, 2'b00});
        end
        @(negedge clk);
        chk(req_ready, "R9 ready after write", 32'(req_ready), 1);
    endtask

    task automatic do_read(input int a, input logic [DW-1:0] e, input bit distract);
        @(negedge clk);
        chk(req_ready, "R2 ready before read", 32'(req_ready), 1);
        req_valid = 1'b1; req_write = 1'b0; req_addr = AW'(a);
        for (int c = 0; c < RD; c++) begin
            @(negedge clk);
            req_valid = distract; req_write = 1'b1; req_wdata = ~e;
            chk(pins() == P_RD && mem_addr == AW'(a) && !rsp_valid && !req_ready,
                "R3 R8 read mode", {pins(), rsp_valid, req_ready, 25'(mem_addr)},
                {P_RD, 2'b00, 25'(a)});
            chk(mem_cs1_n == !mem_cs2, "R10 selects paired", {mem_cs1_n, mem_cs2}, 2'b01);
        end
        for (int c = 0; c < TA; c++) begin
            @(negedge clk);
            if (c == TA - 1) req_valid = 1'b0;
            chk(pins() == P_OFF && !req_ready, "R7 read turnaround",
                {pins(), req_ready}, {P_OFF, 1'b0});
            if (c == 0)
                chk(rsp_valid && rsp_rdata == e, "R4 response", {rsp_valid, rsp_rdata}, {1'b1, e});
            else
                chk(!rsp_valid, "R4 single pulse", 32'(rsp_valid), 0);
        end
        @(negedge clk);
        chk(req_ready, "R9 ready after read", 32'(req_ready), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog act=hung exp=done");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(pins() == P_OFF && req_ready && !rsp_valid, "R1 in reset",
            {pins(), req_ready, rsp_valid}, {P_OFF, 2'b10});
        rst = 1'b0;
        @(negedge clk);
        chk(pins() == P_OFF && req_ready && !rsp_valid, "R1 after reset",
            {pins(), req_ready, rsp_valid}, {P_OFF, 2'b10});
        for (int a = 0; a < WORDS; a++) do_write(a, pat(a));
        for (int a = 0; a < WORDS; a++) do_read(a, pat(a), 1'b1);
        for (int a = WORDS - 1; a >= 0; a--) do_read(a, pat(a), 1'b0);
        do_write(7, 8'h00);
        do_write(7, 8'hFF);
        do_read(7, 8'hFF, 1'b0);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule